// File: doc/BRIEF.md
# Filtered Serial Branch Target Buffer

This block predicts branch targets for a fetch unit while keeping array activity low. Every accepted fetch address is screened by a counting membership filter. When the filter shows that the address cannot be in the main set-associative store, that store is not touched at all. When the filter lets the address through, the main store compares its tags first. It reads the target word only after a tag matches, so a miss never costs a data-array read.

A small direct-mapped bypass store is probed in parallel with the filtered path. When it holds the address, it answers in one cycle, and its answer takes priority over the main store. A main-store hit costs a second cycle. During that cycle the lookup port reports not-ready. The update port writes the bypass slot on every call. It writes the main store when the branch is already present there, or when allocation is requested. Two activity pulses report tag-array and data-array reads.

Top module: `filtered_btb`

## Requirements
- R1: After reset, `lk_ready_o` is 1 and `rsp_valid_o`, `tag_rd_o` and `data_rd_o` are 0. The filter counters are all zero, and every bypass and main entry is invalid.
- R2: The filter has two arrays of 256 three-bit counters. They are indexed by h0 = pc[7:0]^pc[15:8] and h1 = pc[7:0]^pc[23:16]. An accepted lookup passes the filter only when both indexed counters are nonzero. A lookup that does not pass and misses the bypass gets a miss response one cycle after acceptance, with `tag_rd_o` held at 0.
- R3: A main-store allocation increments the new PC's two counters, and evicting a valid entry decrements the evicted PC's two counters. A counter that has reached 7 stays at 7. If an increment and a decrement meet on one counter, that counter is left unchanged.
- R4: `tag_rd_o` is 1 for the one cycle after acceptance exactly when the lookup passed the filter. `data_rd_o` is 1 only in the cycle after such a tag read, and only when that read matched and the bypass missed.
- R5: When the bypass misses and the main store holds the PC, `rsp_valid_o` rises two cycles after acceptance. In that cycle `rsp_slow_o` is 1, `rsp_hit_o` is 1 and `rsp_target_o` carries the stored target.
- R6: The bypass has 32 slots, indexed by pc[4:0] and tagged by pc[31:5]. A bypass hit gives a response one cycle after acceptance, with `rsp_slow_o` at 0 and the bypass target, even when the main store also holds the PC.
- R7: `lk_ready_o` is 0 for exactly the one cycle between acceptance of a main-store hit and its response. A lookup presented during that cycle is ignored and produces no response.
- R8: Every update writes its PC and target into the bypass slot pc[4:0], replacing whatever was there.
- R9: The main store has 64 sets indexed by pc[5:0], with 4 ways each. On an update whose PC is present, the target is rewritten in place. On an update that misses with `upd_alloc_i`=1, the entry goes to the lowest-numbered invalid way, or to the least recently used way when all ways are valid. An update that misses with `upd_alloc_i`=0 leaves the main store unchanged.
- R10: Recency within a set changes only when an update writes a way, and that way becomes the most recent. Lookups do not change recency.
- R11: Any hit response carries the target most recently written for that exact PC. A lookup reports a miss exactly when neither the bypass nor the main store holds the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | 32 | Fetch address to look up |
| lk_ready_o | output | 1 | Lookup can be accepted this cycle |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Response is a hit |
| rsp_slow_o | output | 1 | Hit came from the two-cycle main path |
| rsp_target_o | output | 32 | Predicted target |
| upd_valid_i | input | 1 | Update request |
| upd_pc_i | input | 32 | Branch address being recorded |
| upd_target_i | input | 32 | Resolved target |
| upd_alloc_i | input | 1 | Allocate in main store on a miss |
| tag_rd_o | output | 1 | Pulse: tag array was read |
| data_rd_o | output | 1 | Pulse: data array was read |

## Verification
The assertions assume that update and lookup traffic do not overlap. An update is never presented in the same cycle as a lookup, nor while a two-cycle main access is pending. Under that assumption the target read in the second cycle belongs to the entry that matched. The counter underflow check relies on the same assumption, because evictions are only ever computed against a settled main store. The stimulus keeps to this by issuing one operation at a time and waiting for each response before the next. The one exception is a lookup held high during the not-ready cycle, which exercises the stall.

// File: rtl/fbtb_pkg.sv
package fbtb_pkg;

   // Phase of the lookup pipeline: idle/accepting, or finishing a data read.
   typedef enum logic {
      PH_ACCEPT = 1'b0,
      PH_DATA   = 1'b1
   } fbtb_phase_e;

endpackage

// File: rtl/fbtb_bloom.sv
module fbtb_bloom #(
   parameter int PC_W     = 32,
   parameter int NUM_HASH = 2,
   parameter int IDX_W    = 8,
   parameter int CNT_W    = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [PC_W-1:0] q_pc_i,
   output logic            q_present_o,
   input  logic            inc_en_i,
   input  logic [PC_W-1:0] inc_pc_i,
   input  logic            dec_en_i,
   input  logic [PC_W-1:0] dec_pc_i
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   if (NUM_HASH < 1 || IDX_W * (NUM_HASH + 1) > PC_W || CNT_W < 2) begin : g_bad_cfg
      $error("fbtb_bloom: hash count, index width or counter width out of range");
   end

   // Hash s folds the PC's low slice with the slice s+1 positions above it.
   function automatic logic [IDX_W-1:0] fold(input logic [PC_W-1:0] a, input int unsigned s);
      return IDX_W'(a ^ (a >> (IDX_W * (s + 1))));
   endfunction

   logic [NUM_HASH-1:0] nonzero;

   for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
      logic [CNT_W-1:0] cnt [DEPTH];
      logic [IDX_W-1:0] q_idx, i_idx, d_idx;
      logic             inc_only, dec_only;

      assign q_idx      = fold(q_pc_i, h);
      assign i_idx      = fold(inc_pc_i, h);
      assign d_idx      = fold(dec_pc_i, h);
      assign nonzero[h] = (cnt[q_idx] != '0);
      assign inc_only   = inc_en_i && !(dec_en_i && d_idx == i_idx);
      assign dec_only   = dec_en_i && !(inc_en_i && d_idx == i_idx);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int e = 0; e < DEPTH; e++) cnt[e] <= '0;
         end else begin
            if (inc_only && cnt[i_idx] != CNT_TOP) cnt[i_idx] <= cnt[i_idx] + 1'b1;
            if (dec_only && cnt[d_idx] != CNT_TOP && cnt[d_idx] != '0)
               cnt[d_idx] <= cnt[d_idx] - 1'b1;
         end
      end

      // R3: an eviction only ever removes a PC that was counted in.
      p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         dec_en_i |-> cnt[d_idx] != '0);
   end

   assign q_present_o = &nonzero;
endmodule

// File: rtl/fbtb_bypass.sv
module fbtb_bypass #(
   parameter int PC_W  = 32,
   parameter int TGT_W = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [PC_W-1:0]  q_pc_i,
   output logic             q_hit_o,
   output logic [TGT_W-1:0] q_tgt_o,
   input  logic             wr_en_i,
   input  logic [PC_W-1:0]  wr_pc_i,
   input  logic [TGT_W-1:0] wr_tgt_i
);
   localparam int SLOTS = 1 << IDX_W;
   localparam int TAG_W = PC_W - IDX_W;

   if (IDX_W < 1 || TAG_W < 1) begin : g_bad_cfg
      $error("fbtb_bypass: index width must leave a tag");
   end

   logic             vld  [SLOTS];
   logic [TAG_W-1:0] tagv [SLOTS];
   logic [TGT_W-1:0] tgtv [SLOTS];

   logic [IDX_W-1:0] q_idx, w_idx;
   assign q_idx   = q_pc_i[IDX_W-1:0];
   assign w_idx   = wr_pc_i[IDX_W-1:0];
   assign q_hit_o = vld[q_idx] && (tagv[q_idx] == q_pc_i[PC_W-1:IDX_W]);
   assign q_tgt_o = tgtv[q_idx];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SLOTS; s++) vld[s] <= 1'b0;
      end else if (wr_en_i) begin
         vld[w_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         tagv[w_idx] <= wr_pc_i[PC_W-1:IDX_W];
         tgtv[w_idx] <= wr_tgt_i;
      end
   end
endmodule

// File: rtl/fbtb_main.sv
module fbtb_main #(
   parameter int PC_W  = 32,
   parameter int TGT_W = 32,
   parameter int SET_W = 6,
   parameter int WAYS  = 4
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   // tag-side probe
   input  logic [PC_W-1:0]          q_pc_i,
   output logic                     q_hit_o,
   output logic [$clog2(WAYS)-1:0]  q_way_o,
   // data-side read of a matched way
   input  logic [SET_W-1:0]         rd_set_i,
   input  logic [$clog2(WAYS)-1:0]  rd_way_i,
   output logic [TGT_W-1:0]         rd_tgt_o,
   // update
   input  logic                     upd_en_i,
   input  logic [PC_W-1:0]          upd_pc_i,
   input  logic [TGT_W-1:0]         upd_tgt_i,
   input  logic                     upd_alloc_i,
   output logic                     alloc_o,
   output logic                     evict_o,
   output logic [PC_W-1:0]          evict_pc_o
);
   localparam int SETS  = 1 << SET_W;
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = PC_W - SET_W;
   localparam logic [WAY_W-1:0] AGE_OLD = WAY_W'(WAYS - 1);

   if (WAYS < 2 || (1 << WAY_W) != WAYS || TAG_W < 1) begin : g_bad_cfg
      $error("fbtb_main: ways must be a power of two and the tag non-empty");
   end

   logic             vld  [SETS][WAYS];
   logic [WAY_W-1:0] age  [SETS][WAYS];
   logic [TAG_W-1:0] tagm [SETS][WAYS];
   logic [TGT_W-1:0] tgtm [SETS][WAYS];

   // Tag probe.
   logic [SET_W-1:0] q_set;
   assign q_set = q_pc_i[SET_W-1:0];
   always_comb begin
      q_hit_o = 1'b0;
      q_way_o = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (vld[q_set][w] && tagm[q_set][w] == q_pc_i[PC_W-1:SET_W]) begin
            q_hit_o = 1'b1;
            q_way_o = WAY_W'(w);
         end
      end
   end

   assign rd_tgt_o = tgtm[rd_set_i][rd_way_i];

   // Update: locate the PC, otherwise pick a victim.
   logic [SET_W-1:0] u_set;
   logic [TAG_W-1:0] u_tag;
   logic             u_hit;
   logic [WAY_W-1:0] u_hway, u_vict, u_wway;
   logic             u_wr;
   assign u_set = upd_pc_i[SET_W-1:0];
   assign u_tag = upd_pc_i[PC_W-1:SET_W];

   always_comb begin
      u_hit  = 1'b0;
      u_hway = '0;
      u_vict = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (vld[u_set][w] && tagm[u_set][w] == u_tag) begin
            u_hit  = 1'b1;
            u_hway = WAY_W'(w);
         end
         if (age[u_set][w] == AGE_OLD) u_vict = WAY_W'(w);
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld[u_set][w]) u_vict = WAY_W'(w);
      end
   end

   assign alloc_o    = upd_en_i && !u_hit && upd_alloc_i;
   assign evict_o    = alloc_o && vld[u_set][u_vict];
   assign evict_pc_o = {tagm[u_set][u_vict], u_set};
   assign u_wr       = upd_en_i && (u_hit || upd_alloc_i);
   assign u_wway     = u_hit ? u_hway : u_vict;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               vld[s][w] <= 1'b0;
               age[s][w] <= WAY_W'(w);
            end
         end
      end else if (u_wr) begin
         vld[u_set][u_wway] <= 1'b1;
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == u_wway)
               age[u_set][w] <= '0;
            else if (age[u_set][w] < age[u_set][u_wway])
               age[u_set][w] <= age[u_set][w] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (u_wr) begin
         tagm[u_set][u_wway] <= u_tag;
         tgtm[u_set][u_wway] <= upd_tgt_i;
      end
   end

   // R9: a victim that is still valid is only chosen once no way is free.
   p_evict_full_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evict_o |-> (vld[u_set][0] && vld[u_set][WAYS-1]));
endmodule

// File: rtl/filtered_btb.sv
module filtered_btb #(
   parameter int PC_W      = 32,
   parameter int TGT_W     = 32,
   parameter int SET_W     = 6,
   parameter int WAYS      = 4,
   parameter int BYP_IDX_W = 5,
   parameter int BF_IDX_W  = 8,
   parameter int NUM_HASH  = 2,
   parameter int CNT_W     = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lk_valid_i,
   input  logic [PC_W-1:0]  lk_pc_i,
   output logic             lk_ready_o,
   output logic             rsp_valid_o,
   output logic             rsp_hit_o,
   output logic             rsp_slow_o,
   output logic [TGT_W-1:0] rsp_target_o,
   input  logic             upd_valid_i,
   input  logic [PC_W-1:0]  upd_pc_i,
   input  logic [TGT_W-1:0] upd_target_i,
   input  logic             upd_alloc_i,
   output logic             tag_rd_o,
   output logic             data_rd_o
);
   import fbtb_pkg::*;
   localparam int WAY_W = $clog2(WAYS);

   if (PC_W > 64 || SET_W >= PC_W || BYP_IDX_W >= PC_W) begin : g_bad_cfg
      $error("filtered_btb: index widths must fit inside the PC");
   end

   logic             bf_pass, byp_hit, m_hit, alloc, evict;
   logic [TGT_W-1:0] byp_tgt, m_tgt;
   logic [WAY_W-1:0] m_way;
   logic [PC_W-1:0]  evict_pc;

   fbtb_phase_e      phase;
   logic [SET_W-1:0] pend_set;
   logic [WAY_W-1:0] pend_way;
   logic             accept;

   fbtb_bloom #(.PC_W(PC_W), .NUM_HASH(NUM_HASH), .IDX_W(BF_IDX_W), .CNT_W(CNT_W)) u_filter (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .q_pc_i(lk_pc_i), .q_present_o(bf_pass),
      .inc_en_i(alloc), .inc_pc_i(upd_pc_i),
      .dec_en_i(evict), .dec_pc_i(evict_pc));

   fbtb_bypass #(.PC_W(PC_W), .TGT_W(TGT_W), .IDX_W(BYP_IDX_W)) u_bypass (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .q_pc_i(lk_pc_i), .q_hit_o(byp_hit), .q_tgt_o(byp_tgt),
      .wr_en_i(upd_valid_i), .wr_pc_i(upd_pc_i), .wr_tgt_i(upd_target_i));

   fbtb_main #(.PC_W(PC_W), .TGT_W(TGT_W), .SET_W(SET_W), .WAYS(WAYS)) u_main (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .q_pc_i(lk_pc_i), .q_hit_o(m_hit), .q_way_o(m_way),
      .rd_set_i(pend_set), .rd_way_i(pend_way), .rd_tgt_o(m_tgt),
      .upd_en_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_tgt_i(upd_target_i),
      .upd_alloc_i(upd_alloc_i), .alloc_o(alloc), .evict_o(evict), .evict_pc_o(evict_pc));

   assign lk_ready_o = (phase == PH_ACCEPT);
   assign accept     = lk_valid_i && lk_ready_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase        <= PH_ACCEPT;
         pend_set     <= '0;
         pend_way     <= '0;
         rsp_valid_o  <= 1'b0;
         rsp_hit_o    <= 1'b0;
         rsp_slow_o   <= 1'b0;
         rsp_target_o <= '0;
         tag_rd_o     <= 1'b0;
         data_rd_o    <= 1'b0;
      end else begin
         rsp_valid_o <= 1'b0;
         rsp_slow_o  <= 1'b0;
         tag_rd_o    <= 1'b0;
         data_rd_o   <= 1'b0;
         if (phase == PH_DATA) begin
            phase        <= PH_ACCEPT;
            rsp_valid_o  <= 1'b1;
            rsp_hit_o    <= 1'b1;
            rsp_slow_o   <= 1'b1;
            rsp_target_o <= m_tgt;
            data_rd_o    <= 1'b1;
         end else if (accept) begin
            tag_rd_o <= bf_pass;
            if (byp_hit) begin
               rsp_valid_o  <= 1'b1;
               rsp_hit_o    <= 1'b1;
               rsp_target_o <= byp_tgt;
            end else if (bf_pass && m_hit) begin
               phase    <= PH_DATA;
               pend_set <= lk_pc_i[SET_W-1:0];
               pend_way <= m_way;
            end else begin
               rsp_valid_o  <= 1'b1;
               rsp_hit_o    <= 1'b0;
               rsp_target_o <= '0;
            end
         end
      end
   end

   // R2: a filtered-out lookup with no bypass hit answers a miss at once, with no tag read.
   p_reject_fast_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && !bf_pass && !byp_hit) |=> (rsp_valid_o && !rsp_hit_o && !tag_rd_o));
   // R4: the data array is read only right after a tag read.
   p_data_after_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      data_rd_o |-> $past(tag_rd_o));
   // R5: a slow response is always a hit that used the data array.
   p_slow_is_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && rsp_slow_o) |-> (rsp_hit_o && data_rd_o));
   // R6: a bypass hit answers in one cycle on the fast path.
   p_bypass_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && byp_hit) |=> (rsp_valid_o && rsp_hit_o && !rsp_slow_o));
   // R7: the not-ready cycle always ends in the slow response.
   p_stall_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_ready_o |=> (rsp_valid_o && rsp_slow_o && lk_ready_o));
endmodule

// File: tb/filtered_btb_tb.sv
module filtered_btb_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_ready, rsp_valid, rsp_hit, rsp_slow, tag_rd, data_rd;
   logic [31:0] rsp_target;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic [31:0] upd_target = '0;
   logic        upd_alloc = 1'b0;

   int errs = 0;
   int checks = 0;

   always #10 clk = ~clk;

   filtered_btb dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .lk_valid_i(lk_valid), .lk_pc_i(lk_pc), .lk_ready_o(lk_ready),
      .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_slow_o(rsp_slow),
      .rsp_target_o(rsp_target),
      .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_target_i(upd_target),
      .upd_alloc_i(upd_alloc), .tag_rd_o(tag_rd), .data_rd_o(data_rd));

   // ---------------- behavioural reference ----------------
   bit          byp_v   [32];
   logic [31:0] byp_pc  [32];
   logic [31:0] byp_tg  [32];
   bit          mv      [64][4];
   logic [31:0] mpc     [64][4];
   logic [31:0] mtg     [64][4];
   int          recent  [64][$];   // front = most recent way
   int          cnt     [2][256];

   function automatic int hsh(input logic [31:0] pc, input int k);
      return int'((pc[7:0] ^ (k == 0 ? pc[15:8] : pc[23:16])));
   endfunction

   function automatic bit filter_pass(input logic [31:0] pc);
      return (cnt[0][hsh(pc, 0)] != 0) && (cnt[1][hsh(pc, 1)] != 0);
   endfunction

   task automatic cnt_bump(input logic [31:0] pc, input bit up);
      for (int k = 0; k < 2; k++) begin
         int i;
         i = hsh(pc, k);
         if (cnt[k][i] != 7) cnt[k][i] = up ? cnt[k][i] + 1 : cnt[k][i] - 1;
      end
   endtask

   task automatic touch(input int s, input int w);
      for (int i = 0; i < recent[s].size(); i++) begin
         if (recent[s][i] == w) begin
            recent[s].delete(i);
            break;
         end
      end
      recent[s].push_front(w);
   endtask

   task automatic model_update(input logic [31:0] pc, input logic [31:0] tg, input bit alloc);
      int s, hw, vw;
      s  = int'(pc[5:0]);
      hw = -1;
      byp_v[pc[4:0]]  = 1'b1;
      byp_pc[pc[4:0]] = pc;
      byp_tg[pc[4:0]] = tg;
      for (int w = 0; w < 4; w++) if (mv[s][w] && mpc[s][w] == pc) hw = w;
      if (hw >= 0) begin
         mtg[s][hw] = tg;
         touch(s, hw);
      end else if (alloc) begin
         vw = recent[s][$];
         for (int w = 3; w >= 0; w--) if (!mv[s][w]) vw = w;
         if (mv[s][vw]) cnt_bump(mpc[s][vw], 1'b0);
         cnt_bump(pc, 1'b1);
         mv[s][vw]  = 1'b1;
         mpc[s][vw] = pc;
         mtg[s][vw] = tg;
         touch(s, vw);
      end
   endtask

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_update(input logic [31:0] pc, input logic [31:0] tg, input bit alloc);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_target = tg; upd_alloc = alloc;
      @(negedge clk);
      upd_valid = 1'b0;
      model_update(pc, tg, alloc);
   endtask

   // Issue one lookup; if poke is set, hold a second request during the stall.
   task automatic do_lookup(input logic [31:0] pc, input bit poke, input logic [31:0] poke_pc);
      bit          bhit, pass, mhit, slow;
      logic [31:0] etgt;
      int          s;
      s    = int'(pc[5:0]);
      bhit = byp_v[pc[4:0]] && byp_pc[pc[4:0]] == pc;
      pass = filter_pass(pc);
      mhit = 1'b0;
      etgt = '0;
      for (int w = 0; w < 4; w++) if (mv[s][w] && mpc[s][w] == pc) begin
         mhit = 1'b1;
         etgt = mtg[s][w];
      end
      if (bhit) etgt = byp_tg[pc[4:0]];
      slow = !bhit && mhit;
      @(negedge clk);
      chk(lk_ready == 1'b1, "R7 ready before lookup", 32'(lk_ready), 32'd1);
      lk_valid = 1'b1; lk_pc = pc;
      @(negedge clk);
      chk(tag_rd == pass, "R2/R4 tag read follows filter", 32'(tag_rd), 32'(pass));
      if (!slow) begin
         lk_valid = 1'b0;
         chk(rsp_valid == 1'b1, "R2/R6 fast response", 32'(rsp_valid), 32'd1);
         chk(rsp_hit == bhit, "R11 hit/miss", 32'(rsp_hit), 32'(bhit));
         chk(rsp_slow == 1'b0, "R6 fast flag", 32'(rsp_slow), 32'd0);
         chk(data_rd == 1'b0, "R4 no data read", 32'(data_rd), 32'd0);
         if (bhit) chk(rsp_target == etgt, "R6 bypass target", rsp_target, etgt);
      end else begin
         chk(rsp_valid == 1'b0, "R5 no response yet", 32'(rsp_valid), 32'd0);
         chk(lk_ready == 1'b0, "R7 not ready while busy", 32'(lk_ready), 32'd0);
         if (poke) lk_pc = poke_pc;
         else lk_valid = 1'b0;
         @(negedge clk);
         lk_valid = 1'b0;
         chk(rsp_valid && rsp_hit && rsp_slow, "R5 slow hit", {29'd0, rsp_valid, rsp_hit, rsp_slow}, 32'd7);
         chk(rsp_target == etgt, "R5/R11 main target", rsp_target, etgt);
         chk(data_rd == 1'b1, "R4 data read on match", 32'(data_rd), 32'd1);
         if (poke) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R7 stalled request ignored", 32'(rsp_valid), 32'd0);
         end
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] a, b, c;
      for (int s = 0; s < 64; s++) for (int w = 0; w < 4; w++) recent[s].push_back(w);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(lk_ready == 1'b1, "R1 ready in reset", 32'(lk_ready), 32'd1);
      chk(!rsp_valid && !tag_rd && !data_rd, "R1 idle outputs", {29'd0, rsp_valid, tag_rd, data_rd}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      a = 32'h0000_1040;
      b = 32'h0000_2000;   // same bypass slot and set as a
      c = 32'h0003_7000;
      do_lookup(a, 1'b0, '0);                 // R2: empty filter rejects
      do_update(a, 32'hAAAA_0001, 1'b1);      // R3, R8, R9
      do_lookup(a, 1'b0, '0);                 // R6: bypass hit
      do_update(b, 32'hBBBB_0002, 1'b0);      // R8 overwrite, R9 no allocate
      do_lookup(a, 1'b1, b);                  // R5 main hit, R7 stalled request ignored
      do_lookup(b, 1'b0, '0);                 // R6 bypass holds b
      do_update(c, 32'hCCCC_0003, 1'b0);      // R9: b must not be in main store
      do_lookup(b, 1'b0, '0);                 // R11 miss
      do_update(a, 32'hAAAA_0009, 1'b0);      // R9 in-place target rewrite
      do_update(c, 32'hCCCC_0004, 1'b0);
      do_lookup(a, 1'b0, '0);                 // R5 new target via main
      // R10 / R9: fill set 0 and evict the least recent way
      for (int k = 1; k <= 5; k++) do_update(32'(k) << 12, 32'h5000_0000 + 32'(k), 1'b1);
      do_update(32'h0000_0020, 32'h0, 1'b0);  // move bypass slot 0 away
      for (int k = 1; k <= 5; k++) do_lookup(32'(k) << 12, 1'b0, '0);
      do_lookup(a, 1'b0, '0);
      // mixed traffic over a small aliasing pool
      for (int n = 0; n < 600; n++) begin
         logic [31:0] pc;
         pc = ((32'($urandom) % 4) << 16) | ((32'($urandom) % 8) << 12)
            | ((32'($urandom) % 2) << 5) | ((32'($urandom) % 2) << 6);
         if (($urandom % 3) == 0)
            do_update(pc, $urandom, 1'(($urandom % 4) != 0));
         else
            do_lookup(pc, 1'(($urandom % 2)), 32'h0000_0040);
      end
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule